// File: doc/BRIEF.md
# Interrupt Processor-Target Register Bank

This block keeps, for every shared interrupt, an 8-bit mask that says which processors the interrupt may be sent to. Software reads and writes these masks through a simple register bus with per-byte write strobes. Routing logic samples all masks at once through a flat output vector. The number of processors and the number of interrupts are parameters.

The register window starts at offset 0x800 of the distributor address space. Interrupt n owns the byte at offset 0x800 + n, so each 32-bit word carries four interrupts and lane k of a word (data bits 8k+7 to 8k) belongs to interrupt 4·word + k. The first 32 interrupts are private to each processor. Their fields cannot be written and, on a read, return the one-hot bit of the processor that issues the read. Bits for processors that do not exist and whole words beyond the implemented interrupt count read as zero and ignore writes. So do misaligned and out-of-window addresses.

Top module: `itgt_bank`

## Requirements
- R1: After reset every shared target field is zero, targetVec is all zeros and rspValid is low.
- R2: reqReady is always high. A read accepted in cycle t gives rspValid high with its data in cycle t+1. A write never raises rspValid.
- R3: In every written byte, bits at position NUM_CPUS and above are stored as zero. With NUM_CPUS=4, writing 0xFFFFFFFF reads back 0x0F0F0F0F and writing 0xF1A3520F reads back 0x0103020F.
- R4: A write changes only the byte lanes whose reqBe bit is set, where reqBe[k] covers reqWdata[8k+7:8k].
- R5: On a read, lanes whose reqBe bit is clear return zero. A read with reqBe=0 returns 0.
- R6: Word-aligned addresses in the window whose word index is at or above NUM_IRQS/4 read as zero and ignore writes.
- R7: Words 0 to 7 (interrupts 0 to 31) ignore writes. On a read, each of their lanes returns 1 << reqCpuId, or zero when reqCpuId >= NUM_CPUS.
- R8: An address with reqAddr[1:0] != 0, or outside 0x800 to 0xBFF, selects no register. It reads as zero and ignores writes.
- R9: targetVec[8k+7:8k] holds the field of interrupt 32+k and shows a write in the cycle after the write is accepted.
- R10: Interrupt n is addressed at word 0x800 + (n & ~3), lane n % 4. Writing one lane of word 0x82C changes only the targetVec byte of interrupt 44 + lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | Request valid |
| reqReady | output | 1 | Request accepted (always high) |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 12 | Byte address in distributor space |
| reqWdata | input | 32 | Write data |
| reqBe | input | 4 | Byte-lane enables |
| reqCpuId | input | 3 | Number of the requesting processor |
| rspValid | output | 1 | Read data valid |
| rspRdata | output | 32 | Registered read data |
| targetVec | output | (NUM_IRQS-32)*8 | Target masks of all shared interrupts |

## Verification
The assertions check on every cycle that stored masks never hold a bit for an absent processor, and that the read response arrives one cycle after a read and at no other time. They also check that writes to private, out-of-range or misaligned addresses leave targetVec unchanged, that such reads return zero, and that private reads return the requester's one-hot bit. Only the bench scenarios can show that values come back intact: exact read-back of masked patterns, lane-selective writes and reads, and the mapping from interrupt number to address and to output position.

// File: rtl/itgt_pkg.sv
package itgt_pkg;
  localparam int IDX_W = 8;  // word index inside the 1 KiB window

  typedef struct packed {
    logic             wrShared;   // write to an implemented shared word
    logic             rdShared;   // read of an implemented shared word
    logic             rdPriv;     // read of a private word
    logic             rdAny;      // any accepted read
    logic [3:0]       lane;       // byte lanes selected
    logic [IDX_W-1:0] sharedIdx;  // shared word number (0 = interrupts 32..35)
  } strobe_t;
endpackage

// File: rtl/itgt_ctrl.sv
module itgt_ctrl #(
  parameter int NUM_IRQS = 64
) (
  input  logic               reqValid,
  input  logic               reqWrite,
  input  logic [11:0]        reqAddr,
  input  logic [3:0]         reqBe,
  output itgt_pkg::strobe_t  strb
);
  import itgt_pkg::*;
  localparam int NUM_WORDS  = NUM_IRQS / 4;
  localparam int PRIV_WORDS = 8;

  logic             inWindow, aligned, implemented, isPriv, hit;
  logic [IDX_W-1:0] wordIdx;

  always_comb begin
    inWindow    = (reqAddr[11:10] == 2'b10);
    aligned     = (reqAddr[1:0] == 2'b00);
    wordIdx     = reqAddr[9:2];
    implemented = (int'(wordIdx) < NUM_WORDS);
    isPriv      = (int'(wordIdx) < PRIV_WORDS);
    hit         = reqValid && inWindow && aligned && implemented;

    strb.wrShared  = hit && reqWrite && !isPriv;
    strb.rdShared  = hit && !reqWrite && !isPriv;
    strb.rdPriv    = hit && !reqWrite && isPriv;
    strb.rdAny     = reqValid && !reqWrite;
    strb.lane      = reqBe;
    strb.sharedIdx = wordIdx - IDX_W'(PRIV_WORDS);
  end
endmodule

// File: rtl/itgt_datapath.sv
module itgt_datapath #(
  parameter int NUM_CPUS = 4,
  parameter int NUM_IRQS = 64
) (
  input  logic                         clk,
  input  logic                         rst,
  input  itgt_pkg::strobe_t            strb,
  input  logic [31:0]                  reqWdata,
  input  logic [2:0]                   reqCpuId,
  output logic                         rspValid,
  output logic [31:0]                  rspRdata,
  output logic [(NUM_IRQS-32)*8-1:0]   targetVec
);
  import itgt_pkg::*;
  localparam int SHARED_WORDS = NUM_IRQS / 4 - 8;
  localparam logic [7:0] CPU_MASK = 8'((1 << NUM_CPUS) - 1);

  logic [31:0] wordQ [SHARED_WORDS];

  for (genvar w = 0; w < SHARED_WORDS; w++) begin : g_word
    for (genvar l = 0; l < 4; l++) begin : g_lane
      always_ff @(posedge clk) begin
        if (rst)
          wordQ[w][8*l +: 8] <= '0;
        else if (strb.wrShared && strb.lane[l] && strb.sharedIdx == IDX_W'(w))
          wordQ[w][8*l +: 8] <= reqWdata[8*l +: 8] & CPU_MASK;
      end
    end
    assign targetVec[32*w +: 32] = wordQ[w];
  end

  logic [7:0]  privByte;
  logic [31:0] selWord, rdWord;

  always_comb begin
    privByte = (int'(reqCpuId) < NUM_CPUS) ? (8'd1 << reqCpuId) : 8'd0;
    selWord  = '0;
    for (int w = 0; w < SHARED_WORDS; w++)
      if (strb.sharedIdx == IDX_W'(w)) selWord = wordQ[w];
    rdWord = '0;
    if (strb.rdShared)   rdWord = selWord;
    else if (strb.rdPriv) rdWord = {4{privByte}};
    for (int l = 0; l < 4; l++)
      if (!strb.lane[l]) rdWord[8*l +: 8] = 8'd0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rspValid <= 1'b0;
      rspRdata <= '0;
    end else begin
      rspValid <= strb.rdAny;
      rspRdata <= strb.rdAny ? rdWord : 32'd0;
    end
  end
endmodule

// File: rtl/itgt_bank.sv
module itgt_bank #(
  parameter int NUM_CPUS = 4,
  parameter int NUM_IRQS = 64
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        reqValid,
  output logic                        reqReady,
  input  logic                        reqWrite,
  input  logic [11:0]                 reqAddr,
  input  logic [31:0]                 reqWdata,
  input  logic [3:0]                  reqBe,
  input  logic [2:0]                  reqCpuId,
  output logic                        rspValid,
  output logic [31:0]                 rspRdata,
  output logic [(NUM_IRQS-32)*8-1:0]  targetVec
);
  itgt_pkg::strobe_t strb;

  assign reqReady = 1'b1;

  itgt_ctrl #(.NUM_IRQS(NUM_IRQS)) u_ctrl (
    .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqBe(reqBe), .strb(strb)
  );

  itgt_datapath #(.NUM_CPUS(NUM_CPUS), .NUM_IRQS(NUM_IRQS)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .reqWdata(reqWdata),
    .reqCpuId(reqCpuId), .rspValid(rspValid), .rspRdata(rspRdata),
    .targetVec(targetVec)
  );
endmodule

// File: rtl/itgt_bank_chk.sv
module itgt_bank_chk #(
  parameter int NUM_CPUS = 4,
  parameter int NUM_IRQS = 64
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        reqValid,
  input logic                        reqWrite,
  input logic [11:0]                 reqAddr,
  input logic [3:0]                  reqBe,
  input logic [2:0]                  reqCpuId,
  input logic                        rspValid,
  input logic [31:0]                 rspRdata,
  input logic [(NUM_IRQS-32)*8-1:0]  targetVec
);
  localparam int FIELDS = NUM_IRQS - 32;
  localparam logic [7:0] CPU_MASK = 8'((1 << NUM_CPUS) - 1);
  localparam logic [FIELDS*8-1:0] REPL = {FIELDS{CPU_MASK}};

  logic isRead, inWin, misaligned, beyond, priv;
  logic [7:0] expPriv;
  always_comb begin
    isRead     = reqValid && !reqWrite;
    inWin      = (reqAddr >= 12'h800) && (reqAddr <= 12'hBFF);
    misaligned = (reqAddr[1:0] != 2'b00) || !inWin;
    beyond     = inWin && (int'(reqAddr - 12'h800) >= NUM_IRQS);
    priv       = inWin && (int'(reqAddr - 12'h800) < 32);
    expPriv    = (int'(reqCpuId) < NUM_CPUS) ? (8'd1 << reqCpuId) : 8'd0;
  end

  a_r2_rsp_follows_read: assert property (@(posedge clk) disable iff (rst)
    isRead |=> rspValid);
  a_r2_no_rsp_without_read: assert property (@(posedge clk) disable iff (rst)
    !isRead |=> !rspValid);
  a_r3_absent_cpu_bits_clear: assert property (@(posedge clk) disable iff (rst)
    (targetVec & ~REPL) == '0);
  a_r5_no_lane_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (isRead && reqBe == 4'b0000) |=> rspRdata == 32'd0);
  a_r6_beyond_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqWrite && beyond) |=> $stable(targetVec));
  a_r6_beyond_read_zero: assert property (@(posedge clk) disable iff (rst)
    (isRead && beyond) |=> rspRdata == 32'd0);
  a_r7_priv_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqWrite && priv) |=> $stable(targetVec));
  a_r7_priv_read_onehot: assert property (@(posedge clk) disable iff (rst)
    (isRead && priv && !misaligned && reqBe == 4'hF) |=> rspRdata == {4{$past(expPriv)}});
  a_r8_bad_addr_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqWrite && misaligned) |=> $stable(targetVec));
  a_r8_bad_addr_read_zero: assert property (@(posedge clk) disable iff (rst)
    (isRead && misaligned) |=> rspRdata == 32'd0);
endmodule

bind itgt_bank itgt_bank_chk #(.NUM_CPUS(NUM_CPUS), .NUM_IRQS(NUM_IRQS)) u_chk (
  .clk(clk), .rst(rst), .reqValid(reqValid), .reqWrite(reqWrite),
  .reqAddr(reqAddr), .reqBe(reqBe), .reqCpuId(reqCpuId),
  .rspValid(rspValid), .rspRdata(rspRdata), .targetVec(targetVec)
);

// File: tb/test_itgt_bank.sv
`timescale 1ns/1ps
module test_itgt_bank;
  localparam int NUM_CPUS = 4;
  localparam int NUM_IRQS = 64;
  localparam int FIELDS   = NUM_IRQS - 32;
  localparam logic [7:0] MASK = 8'h0F;

  logic clk = 1'b0, rst = 1'b1;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [11:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic [3:0]  reqBe = '0;
  logic [2:0]  reqCpuId = '0;
  logic reqReady, rspValid;
  logic [31:0] rspRdata;
  logic [FIELDS*8-1:0] targetVec;

  int vectors = 0, misses = 0, cycles = 0;
  logic [7:0] expField [FIELDS];

  always #10 clk = ~clk;

  itgt_bank #(.NUM_CPUS(NUM_CPUS), .NUM_IRQS(NUM_IRQS)) i_itgt_bank (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .reqBe(reqBe), .reqCpuId(reqCpuId), .rspValid(rspValid),
    .rspRdata(rspRdata), .targetVec(targetVec)
  );

  task automatic check(string req, logic [255:0] act, logic [255:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [FIELDS*8-1:0] expVec();
    logic [FIELDS*8-1:0] v;
    for (int k = 0; k < FIELDS; k++) v[8*k +: 8] = expField[k];
    return v;
  endfunction

  task automatic doWrite(logic [11:0] a, logic [31:0] d, logic [3:0] be);
    @(negedge clk);
    reqValid = 1; reqWrite = 1; reqAddr = a; reqWdata = d; reqBe = be;
    @(negedge clk);
    reqValid = 0; reqWrite = 0;
  endtask

  task automatic doRead(logic [11:0] a, logic [3:0] be, logic [2:0] cpu,
                        output logic [31:0] d, output logic v);
    @(negedge clk);
    reqValid = 1; reqWrite = 0; reqAddr = a; reqBe = be; reqCpuId = cpu;
    @(negedge clk);
    d = rspRdata; v = rspValid;
    reqValid = 0;
  endtask

  // model update for a shared word, masked per requirement R3/R4
  task automatic modelWrite(int word, logic [31:0] d, logic [3:0] be);
    for (int l = 0; l < 4; l++)
      if (be[l]) expField[(word - 8) * 4 + l] = d[8*l +: 8] & MASK;
  endtask

  task automatic testReset();
    logic [31:0] d; logic v;
    check("R1 rspValid", 256'(rspValid), 256'(0));
    check("R1 targetVec", 256'(targetVec), 256'(0));
    doRead(12'h820, 4'hF, 3'd0, d, v);
    check("R1 shared word reads zero", 256'(d), 256'(0));
  endtask

  task automatic testMaskAndHandshake();
    logic [31:0] d; logic v;
    check("R2 ready high", 256'(reqReady), 256'(1));
    doWrite(12'h820, 32'hFFFF_FFFF, 4'hF); modelWrite(8, 32'hFFFF_FFFF, 4'hF);
    check("R2 no rsp after write", 256'(rspValid), 256'(0));
    doRead(12'h820, 4'hF, 3'd0, d, v);
    check("R2 rsp valid after read", 256'(v), 256'(1));
    check("R3 all ones masked", 256'(d), 256'(32'h0F0F_0F0F));
    doWrite(12'h820, 32'hF1A3_520F, 4'hF); modelWrite(8, 32'hF1A3_520F, 4'hF);
    doRead(12'h820, 4'hF, 3'd1, d, v);
    check("R3 pattern masked", 256'(d), 256'(32'h0103_020F));
    check("R9 targetVec after word write", 256'(targetVec), 256'(expVec()));
  endtask

  task automatic testLanes();
    logic [31:0] d; logic v;
    doWrite(12'h824, 32'h0102_0304, 4'hF); modelWrite(9, 32'h0102_0304, 4'hF);
    doWrite(12'h824, 32'hFF0B_FFFF, 4'b0100); modelWrite(9, 32'hFF0B_FFFF, 4'b0100);
    doRead(12'h824, 4'hF, 3'd0, d, v);
    check("R4 single lane write", 256'(d), 256'(32'h010B_0304));
    check("R4 targetVec", 256'(targetVec), 256'(expVec()));
    doRead(12'h824, 4'b0010, 3'd0, d, v);
    check("R5 single lane read", 256'(d), 256'(32'h0000_0300));
    doRead(12'h824, 4'b0000, 3'd0, d, v);
    check("R5 no lanes read", 256'(d), 256'(0));
  endtask

  task automatic testBeyondAndBad();
    logic [31:0] d; logic v;
    doWrite(12'h840, 32'hFFFF_FFFF, 4'hF);
    check("R6 beyond write ignored", 256'(targetVec), 256'(expVec()));
    doRead(12'h840, 4'hF, 3'd0, d, v);
    check("R6 beyond read zero", 256'(d), 256'(0));
    doRead(12'hBFC, 4'hF, 3'd0, d, v);
    check("R6 window end reads zero", 256'(d), 256'(0));
    doWrite(12'h821, 32'hFFFF_FFFF, 4'hF);
    check("R8 misaligned write ignored", 256'(targetVec), 256'(expVec()));
    doRead(12'h821, 4'hF, 3'd0, d, v);
    check("R8 misaligned read zero", 256'(d), 256'(0));
    doWrite(12'h420, 32'hFFFF_FFFF, 4'hF);
    check("R8 out of window write ignored", 256'(targetVec), 256'(expVec()));
    doRead(12'h420, 4'hF, 3'd0, d, v);
    check("R8 out of window read zero", 256'(d), 256'(0));
  endtask

  task automatic testPrivate();
    logic [31:0] d; logic v;
    doRead(12'h800, 4'hF, 3'd2, d, v);
    check("R7 cpu2 private read", 256'(d), 256'(32'h0404_0404));
    doRead(12'h81C, 4'hF, 3'd3, d, v);
    check("R7 cpu3 private read", 256'(d), 256'(32'h0808_0808));
    doRead(12'h810, 4'hF, 3'd5, d, v);
    check("R7 absent cpu reads zero", 256'(d), 256'(0));
    doWrite(12'h81C, 32'hFFFF_FFFF, 4'hF);
    check("R7 private write ignored", 256'(targetVec), 256'(expVec()));
    doRead(12'h81C, 4'hF, 3'd0, d, v);
    check("R7 private read after write", 256'(d), 256'(32'h0101_0101));
  endtask

  task automatic testMapping();
    logic [31:0] d; logic v;
    // interrupt 47: word 0x82C, lane 3
    doWrite(12'h82C, 32'h0A00_0000, 4'b1000); modelWrite(11, 32'h0A00_0000, 4'b1000);
    check("R10 irq47 byte", 256'(targetVec[(47-32)*8 +: 8]), 256'(8'h0A));
    check("R10 whole vector", 256'(targetVec), 256'(expVec()));
    doWrite(12'h83C, 32'h0506_0708, 4'hF); modelWrite(15, 32'h0506_0708, 4'hF);
    doRead(12'h83C, 4'hF, 3'd0, d, v);
    check("R9 last shared word", 256'(d), 256'(32'h0506_0708));
    check("R9 last word in targetVec", 256'(targetVec), 256'(expVec()));
  endtask

  initial begin
    for (int k = 0; k < FIELDS; k++) expField[k] = 8'd0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    testReset();
    testMaskAndHandshake();
    testLanes();
    testBeyondAndBad();
    testPrivate();
    testMapping();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      vectors++; misses++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule